// File: doc/BRIEF.md
# Bipolar Stepping Motor Pulse Former

This block produces the coil drive for the two-terminal bipolar stepping motor of an analog clock. It runs from a fast system clock. It advances only on a one-cycle enable that occurs 32768 times per second, so every duration is a count of those enable ticks. Once per motor period it drives a pulse of fixed width across the coil. Between pulses it holds both terminals low. The direction of the coil current reverses on every pulse, which is what steps the rotor.

Three parameters, all given in enable ticks, set the timing: the normal period, the pulse width and a separate period for a mechanical test mode. Typical normal periods are 125 ms, 250 ms, 500 ms, 2 s or 16 s, which are 4096, 8192, 16384, 65536 or 524288 ticks. Typical widths are 15.6, 23.4, 31.25 or 46.9 ms; for example 23.4 ms is 768 ticks and 31.25 ms is 1024 ticks. The test period is 250 ms, 500 ms or 1 s.

A test-mode level from the input controller selects the test period in place of the normal one. The width does not change. A change of mode is taken only at a period boundary. A one-cycle strobe marks the first cycle of every pulse.

Top module: `motor_pulse_former`

## Requirements
- R1: After a synchronous active-low reset, `drive_a`, `drive_b` and `pulse_start` are 0, and the first enable tick after reset starts a pulse with `drive_a`=1 and `drive_b`=0.
- R2: The state advances only on cycles with `tick_en`=1; on any number of cycles without a tick, all outputs hold their values.
- R3: Each pulse lasts exactly PULSE_TICKS enable ticks, counted from the tick that starts it to the tick that ends it.
- R4: With test mode off, successive pulse starts are PERIOD_TICKS enable ticks apart.
- R5: Between pulses both `drive_a` and `drive_b` are 0.
- R6: During a pulse exactly one output is 1. The 1 is on `drive_a` for the 1st, 3rd, 5th, ... pulse after reset and on `drive_b` for the 2nd, 4th, ... pulse.
- R7: With test mode on, successive pulse starts are TEST_PERIOD_TICKS ticks apart and the pulse width remains PULSE_TICKS.
- R8: The level of `test_mode` is sampled only on the tick that starts a pulse. That value sets the length of the period this pulse opens. A change at any other time neither shortens nor stretches the pulse or the period in progress.
- R9: `pulse_start` is 1 for exactly one clock cycle, the first cycle in which the new pulse is driven, and is 0 otherwise.
- R10: A configuration whose period (normal or test) is neither at least four times nor exactly twice the pulse width fails at elaboration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_en | input | 1 | One-cycle enable at 32768 Hz; every duration is counted in these ticks |
| test_mode | input | 1 | 1 selects the test period; sampled at each pulse start |
| drive_a | output | 1 | Coil terminal A level, 1 = driven high |
| drive_b | output | 1 | Coil terminal B level, 1 = driven high |
| pulse_start | output | 1 | One-cycle strobe in the first cycle of each pulse |

## Verification
The bench uses a small configuration: a 3-tick pulse, a 14-tick normal period (four-times rule) and a 6-tick test period (exact-twice rule). The enable is first given on every cycle and then sparsely. Agreement between the two separates tick counting from cycle counting. A long stall with the enable held low in the middle of a pulse shows whether anything moves without a tick. The mode level is flipped at every offset across two full periods, both inside and outside pulses. Each interval is checked against the mode seen at its opening tick, which distinguishes sampling at the boundary from acting at once. A reset in the middle of a pulse confirms the idle levels and that polarity restarts on terminal A.

// File: rtl/mpf_pkg.sv
// Package: shared helpers for the motor pulse former.
// Assumes all durations are expressed in 32768 Hz enable ticks.
package mpf_pkg;

    // Legality rule for a period against the pulse width.
    function automatic bit mpf_cfg_legal(input int period_ticks, input int pulse_ticks);
        return (pulse_ticks >= 1) &&
               ((period_ticks >= 4 * pulse_ticks) || (period_ticks == 2 * pulse_ticks));
    endfunction

    // Larger of two tick counts, used to size the phase counter.
    function automatic int mpf_max(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/mpf_phase_counter.sv
// Module: mpf_phase_counter
// Counts enable ticks across one motor period and frames the pulse window.
// The counter value 0 means "next tick opens a pulse". The period length for
// the upcoming period is latched from test_mode on that opening tick.
// Assumes PULSE_TICKS < both period lengths (guaranteed by the top's check).
module mpf_phase_counter
    import mpf_pkg::*;
#(
    parameter int PERIOD_TICKS      = 65536,
    parameter int PULSE_TICKS       = 768,
    parameter int TEST_PERIOD_TICKS = 8192
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_en,
    input  logic test_mode,
    output logic pulse_on,
    output logic pulse_start,
    output logic pulse_end_evt
);
    localparam int MAX_PERIOD = mpf_max(PERIOD_TICKS, TEST_PERIOD_TICKS);
    localparam int CNT_W      = (MAX_PERIOD > 2) ? $clog2(MAX_PERIOD) : 1;
    localparam logic [CNT_W-1:0] NORM_LAST = CNT_W'(PERIOD_TICKS - 1);
    localparam logic [CNT_W-1:0] TEST_LAST = CNT_W'(TEST_PERIOD_TICKS - 1);
    localparam logic [CNT_W-1:0] PULSE_END = CNT_W'(PULSE_TICKS);

    logic [CNT_W-1:0] phase_cnt;
    logic             use_test;
    logic [CNT_W-1:0] cur_last;
    logic             at_open;
    logic             at_close;
    logic             at_wrap;

    // Decode the boundaries of the current period and pulse.
    always_comb begin
        cur_last = use_test ? TEST_LAST : NORM_LAST;
        at_open  = tick_en && (phase_cnt == '0);
        at_close = tick_en && (phase_cnt == PULSE_END);
        at_wrap  = tick_en && (phase_cnt == cur_last);
    end

    // Advance the phase counter and latch the mode at each pulse opening.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_cnt <= '0;
            use_test  <= 1'b0;
        end else begin
            if (tick_en) begin
                phase_cnt <= at_wrap ? '0 : phase_cnt + 1'b1;
            end
            if (at_open) begin
                use_test <= test_mode;
            end
        end
    end

    // Hold the pulse window and the opening strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulse_on    <= 1'b0;
            pulse_start <= 1'b0;
        end else begin
            pulse_start <= at_open;
            if (at_open) begin
                pulse_on <= 1'b1;
            end else if (at_close) begin
                pulse_on <= 1'b0;
            end
        end
    end

    assign pulse_end_evt = at_close;

    // R8: the counter never runs past the last phase of the selected period.
    assert_phase_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        phase_cnt <= cur_last);

    // R2: without a tick the phase and the pulse window stay frozen.
    assert_hold_without_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_en |=> ($stable(phase_cnt) && $stable(pulse_on) && !pulse_start));

endmodule

// File: rtl/mpf_polarity.sv
// Module: mpf_polarity
// Remembers which terminal carries the next pulse. It flips when a pulse
// closes, so consecutive pulses use opposite terminals.
// Assumes close events arrive only while a pulse is active.
module mpf_polarity (
    input  logic clk,
    input  logic rst_n,
    input  logic pulse_end_evt,
    output logic use_b
);
    // Toggle the terminal selection at the close of every pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            use_b <= 1'b0;
        end else if (pulse_end_evt) begin
            use_b <= ~use_b;
        end
    end
endmodule

// File: rtl/mpf_drive_stage.sv
// Module: mpf_drive_stage
// Maps the pulse window and polarity onto the two terminal levels.
// Outside a pulse both terminals are low.
// Assumes the polarity changes only while the pulse window is closed.
module mpf_drive_stage (
    input  logic pulse_on,
    input  logic use_b,
    output logic drive_a,
    output logic drive_b
);
    // Steer the active level to one terminal.
    always_comb begin
        drive_a = pulse_on && !use_b;
        drive_b = pulse_on &&  use_b;
    end
endmodule

// File: rtl/motor_pulse_former.sv
// Module: motor_pulse_former (top)
// Generates alternating-polarity pulses for a two-terminal stepping motor.
// Timing is counted in 32768 Hz enable ticks. The test mode replaces the
// period at the next boundary, and the width stays the same.
// Assumes tick_en is a single-cycle enable and rst_n is synchronous.
module motor_pulse_former
    import mpf_pkg::*;
#(
    parameter int PERIOD_TICKS      = 65536,
    parameter int PULSE_TICKS       = 768,
    parameter int TEST_PERIOD_TICKS = 8192
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_en,
    input  logic test_mode,
    output logic drive_a,
    output logic drive_b,
    output logic pulse_start
);
    // R10: reject period/width combinations outside the allowed ratios.
    if (!mpf_cfg_legal(PERIOD_TICKS, PULSE_TICKS)) begin : g_bad_norm_R10
        $error("normal period %0d ticks illegal for pulse %0d ticks", PERIOD_TICKS, PULSE_TICKS);
    end
    if (!mpf_cfg_legal(TEST_PERIOD_TICKS, PULSE_TICKS)) begin : g_bad_test_R10
        $error("test period %0d ticks illegal for pulse %0d ticks", TEST_PERIOD_TICKS, PULSE_TICKS);
    end

    logic pulse_on;
    logic pulse_end_evt;
    logic use_b;

    mpf_phase_counter #(
        .PERIOD_TICKS      (PERIOD_TICKS),
        .PULSE_TICKS       (PULSE_TICKS),
        .TEST_PERIOD_TICKS (TEST_PERIOD_TICKS)
    ) u_phase (
        .clk           (clk),
        .rst_n         (rst_n),
        .tick_en       (tick_en),
        .test_mode     (test_mode),
        .pulse_on      (pulse_on),
        .pulse_start   (pulse_start),
        .pulse_end_evt (pulse_end_evt)
    );

    mpf_polarity u_pol (
        .clk           (clk),
        .rst_n         (rst_n),
        .pulse_end_evt (pulse_end_evt),
        .use_b         (use_b)
    );

    mpf_drive_stage u_drive (
        .pulse_on (pulse_on),
        .use_b    (use_b),
        .drive_a  (drive_a),
        .drive_b  (drive_b)
    );

    // R6: each closed pulse hands the next one to the other terminal.
    assert_alternate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pulse_on) |-> (use_b != $past(use_b)));

    // R9: a pulse window opens only together with the strobe.
    assert_open_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pulse_on) |-> pulse_start);

    // R9: the strobe lasts a single cycle.
    assert_strobe_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_start |=> !pulse_start);

    // R5: a new pulse starts only from the idle state with both terminals low.
    assert_start_from_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_start |-> $past(!drive_a && !drive_b));

    // R6: a started pulse drives exactly one terminal.
    assert_one_hot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_start |-> $countones({drive_a, drive_b}) == 1);

endmodule

// File: tb/tb_motor_pulse_former.sv
module tb_motor_pulse_former;
    localparam int PERIOD = 14;
    localparam int PULSE  = 3;
    localparam int TPER   = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_en = 1'b0;
    logic test_mode = 1'b0;
    logic drive_a, drive_b, pulse_start;

    int checks = 0;
    int fails = 0;
    int ticks = 0;
    int n_pulse = 0;
    int start_tick = 0;
    bit have_prev = 0;
    bit prev_on = 0;
    bit prev_strobe = 0;
    bit latched_test = 0;
    bit done = 0;
    int overlap_errs = 0;
    int strobe_errs = 0;

    always #4 clk = ~clk;

    motor_pulse_former #(
        .PERIOD_TICKS(PERIOD), .PULSE_TICKS(PULSE), .TEST_PERIOD_TICKS(TPER)
    ) dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .test_mode(test_mode),
        .drive_a(drive_a), .drive_b(drive_b), .pulse_start(pulse_start)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Compare the sampled outputs with the arithmetic model.
    task automatic observe();
        bit on;
        int exp_p;
        on = drive_a || drive_b;
        if (drive_a && drive_b) overlap_errs++;
        if (pulse_start && prev_strobe) strobe_errs++;
        if (pulse_start) begin
            check(drive_a == (n_pulse % 2 == 0) && drive_b == (n_pulse % 2 == 1),
                  (n_pulse == 0) ? "R1 R6 first pulse on A" : "R6 polarity",
                  {drive_a, drive_b}, (n_pulse % 2 == 0) ? 2 : 1);
            if (have_prev) begin
                exp_p = latched_test ? TPER : PERIOD;
                check(ticks - start_tick == exp_p,
                      latched_test ? "R7 R8 test period" : "R4 R8 normal period",
                      ticks - start_tick, exp_p);
            end
            have_prev = 1;
            start_tick = ticks;
            latched_test = test_mode;
            n_pulse++;
        end
        if (prev_on && !on) begin
            check(ticks - start_tick == PULSE, latched_test ? "R7 R3 width" : "R3 width",
                  ticks - start_tick, PULSE);
            check(!drive_a && !drive_b, "R5 idle low", {drive_a, drive_b}, 0);
        end
        prev_on = on;
        prev_strobe = pulse_start;
    endtask

    task automatic cycle(input bit t);
        tick_en = t;
        @(posedge clk);
        if (t && rst_n) ticks++;
        @(negedge clk);
        if (rst_n) observe();
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        tick_en = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(!drive_a && !drive_b && !pulse_start, "R1 reset idle",
              {drive_a, drive_b, pulse_start}, 0);
        rst_n = 1'b1;
        n_pulse = 0;
        have_prev = 0;
        prev_on = 0;
        prev_strobe = 0;
    endtask

    initial begin
        bit sa, sb, ss, moved;
        do_reset();
        // Dense ticks, normal mode: several periods.
        for (int i = 0; i < 60; i++) cycle(1'b1);
        // Sparse ticks, every third cycle.
        for (int i = 0; i < 120; i++) cycle(i % 3 == 0);
        // Reach a pulse, then stall the enable (R2).
        while (!(drive_a || drive_b)) cycle(1'b1);
        cycle(1'b1);
        sa = drive_a; sb = drive_b; ss = pulse_start; moved = 0;
        for (int i = 0; i < 40; i++) begin
            cycle(1'b0);
            if (drive_a != sa || drive_b != sb || pulse_start) moved = 1;
        end
        check(!moved, "R2 no change without tick", moved, 0);
        // Mode flip at every offset over two periods (R7, R8).
        for (int k = 0; k < 2 * PERIOD; k++) begin
            for (int i = 0; i < k; i++) cycle(1'b1);
            test_mode = ~test_mode;
            for (int i = 0; i < 3 * PERIOD; i++) cycle((i % 5) != 2);
        end
        test_mode = 1'b1;
        for (int i = 0; i < 40; i++) cycle(1'b1);
        test_mode = 1'b0;
        for (int i = 0; i < 40; i++) cycle(1'b1);
        // Reset in the middle of a pulse, restart on terminal A (R1).
        while (!(drive_a || drive_b)) cycle(1'b1);
        cycle(1'b1);
        do_reset();
        for (int i = 0; i < 50; i++) cycle(1'b1);
        check(overlap_errs == 0, "R6 never both high", overlap_errs, 0);
        check(strobe_errs == 0, "R9 strobe one cycle", strobe_errs, 0);
        check(n_pulse > 3, "R9 strobes seen after reset", n_pulse, 4);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule